// File: doc/BRIEF.md
# Serial Controller Interrupt Generator

This block produces the interrupt lines of a serial peripheral controller. A mode input chooses between two ways of signalling. In single-buffer mode, a transfer-complete event and a receive-overrun event both go to one combined line, `irq_rx`, and the transmit line stays quiet. In FIFO mode, the combined line instead carries a receive-threshold interrupt, and a separate transmit line carries a transmit-threshold interrupt. Each threshold interrupt comes from comparing a FIFO occupancy count with a threshold level that software programs.

The shift engine sends a one-cycle `xfer_done` pulse each time it shifts the last bit of a character. At that moment the character enters the receive buffer. A read of that buffer is reported by `rxbuf_rd`. Software writes the enable bits, the threshold levels and the write-one clear strobes. The FIFO storage supplies its occupancy counts. All flags are readable at the ports, and both interrupt lines are registered levels.

Top module: `spi_irq_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every flag and both interrupt lines become 0.
- R2: `done_flag` is 1 starting one clock after an `xfer_done` pulse. It returns to 0 one clock after `rxbuf_rd` or `done_clr`. When a set and a clear arrive in the same cycle, the set wins.
- R3: In single-buffer mode (`fifo_mode`=0), `irq_rx` is 1 when `done_flag` and `done_ie` are both 1, or when a latched overrun request is present and `ovr_ie` is 1.
- R4: An overrun occurs when `xfer_done` arrives while the previous character is still unread, meaning no `rxbuf_rd` since the last `xfer_done`. `ovr_flag` then sets one clock later. Only `ovr_clr` clears it; `rxbuf_rd` does not.
- R5: An overrun latches an interrupt request only if `ovr_ie` is 1 and `ovr_flag` was 0 when it occurred. The request lasts until `ovr_clr`.
- R6: While `ovr_flag` is already set, further overruns do not raise the interrupt, even after `ovr_ie` is turned on.
- R7: In FIFO mode, `rxff_flag` sets one clock after a cycle in which `rx_count` >= `rx_level`. It stays set after the count falls.
- R8: In FIFO mode, `txff_flag` sets one clock after a cycle in which `tx_count` <= `tx_level`. It stays set until cleared.
- R9: A write-one clear strobe (`rxff_clr` or `txff_clr`) clears its FIFO flag at the next edge. The flag sets again one clock later if the comparison still holds.
- R10: In FIFO mode, `irq_rx` equals `rxff_flag` AND `rxff_ie`. Transfer-complete and overrun do not reach it.
- R11: `irq_tx` is 0 whenever `fifo_mode` was 0 at the previous edge. In FIFO mode, it equals `txff_flag` AND `txff_ie`.
- R12: The interrupt lines follow a change of flag or enable one clock later, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 0 = single-buffer mode, 1 = FIFO mode |
| xfer_done | input | 1 | Pulse: last bit of a character shifted |
| rxbuf_rd | input | 1 | Strobe: receive buffer read |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_level | input | CNT_W | Receive threshold level |
| tx_level | input | CNT_W | Transmit threshold level |
| done_ie | input | 1 | Transfer-complete interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| rxff_ie | input | 1 | Receive threshold interrupt enable |
| txff_ie | input | 1 | Transmit threshold interrupt enable |
| done_clr | input | 1 | Clear strobe for `done_flag` |
| ovr_clr | input | 1 | Clear strobe for `ovr_flag` and its request |
| rxff_clr | input | 1 | Write-one clear for `rxff_flag` |
| txff_clr | input | 1 | Write-one clear for `txff_flag` |
| irq_rx | output | 1 | Combined (single-buffer) or receive (FIFO) interrupt |
| irq_tx | output | 1 | Transmit interrupt, FIFO mode only |
| done_flag | output | 1 | Transfer-complete flag |
| ovr_flag | output | 1 | Receive overrun flag |
| rxff_flag | output | 1 | Receive threshold flag |
| txff_flag | output | 1 | Transmit threshold flag |

## Verification
The bench builds the block with its default count width of 5 bits, so occupancies and levels cover 0 through 16. This makes it possible to test the equality boundary of both comparisons, and the full-FIFO case in which count and level are both 16. The directed scenarios cover several situations: overruns that arrive while the overrun flag is already set, enables changed after an event, and a clear strobe issued while a comparison still holds. The single-buffer sources are also checked while FIFO mode hides them, and again when single-buffer mode lets them through.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_FIFO   = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic done;
        logic ovr_req;
        logic rxff;
        logic txff;
    } irq_src_t;

    typedef struct packed {
        logic done;
        logic ovr;
        logic rxff;
        logic txff;
    } irq_en_t;

    typedef struct packed {
        logic rx;
        logic tx;
    } irq_lines_t;

    function automatic irq_lines_t irq_merge(input irq_mode_e mode,
                                             input irq_src_t  src,
                                             input irq_en_t   en);
        irq_lines_t l;
        if (mode == MODE_FIFO) begin
            l.rx = src.rxff & en.rxff;
            l.tx = src.txff & en.txff;
        end else begin
            l.rx = (src.done & en.done) | (src.ovr_req & en.ovr);
            l.tx = 1'b0;
        end
        return l;
    endfunction

endpackage

// File: rtl/spi_irq_xfer_flags.sv
module spi_irq_xfer_flags (
    input  logic clk,
    input  logic rst,
    input  logic xfer_done,
    input  logic rxbuf_rd,
    input  logic done_clr,
    input  logic ovr_clr,
    input  logic ovr_ie,
    output logic done_flag,
    output logic ovr_flag,
    output logic ovr_req
);
    logic rx_full;
    logic overrun_evt;

    assign overrun_evt = xfer_done & rx_full & ~rxbuf_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full   <= 1'b0;
            done_flag <= 1'b0;
            ovr_flag  <= 1'b0;
            ovr_req   <= 1'b0;
        end else begin
            rx_full   <= xfer_done | (rx_full & ~rxbuf_rd);
            done_flag <= xfer_done | (done_flag & ~rxbuf_rd & ~done_clr);
            ovr_flag  <= overrun_evt | (ovr_flag & ~ovr_clr);
            ovr_req   <= (overrun_evt & ~ovr_flag & ovr_ie) | (ovr_req & ~ovr_clr);
        end
    end

    // R2
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> done_flag);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && rx_full && !rxbuf_rd) |=> ovr_flag);

    // R4
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R6
    no_retrig_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_req && !ovr_clr) |=> !ovr_req);

endmodule

// File: rtl/spi_irq_fifo_flag.sv
module spi_irq_fifo_flag #(
    parameter int unsigned CNT_W = 5,
    parameter bit          IS_TX = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             clr,
    output logic             flag
);
    logic hit;

    generate
        if (IS_TX) begin : g_tx_cmp
            assign hit = (count <= level);
        end else begin : g_rx_cmp
            assign hit = (count >= level);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else begin
            flag <= flag | (active & hit);
        end
    end

    // R9
    ff_clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag);

    // R7
    ff_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
    import spi_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode,
    input  irq_src_t  src,
    input  irq_en_t   en,
    output logic      irq_rx,
    output logic      irq_tx
);
    irq_lines_t nxt;

    always_comb nxt = irq_merge(mode, src, en);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_rx <= 1'b0;
            irq_tx <= 1'b0;
        end else begin
            irq_rx <= nxt.rx;
            irq_tx <= nxt.tx;
        end
    end

    // R11
    tx_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE) |=> !irq_tx);

    // R10
    fifo_rx_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FIFO && !src.rxff) |=> !irq_rx);

endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen
    import spi_irq_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_mode,
    input  logic             xfer_done,
    input  logic             rxbuf_rd,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic             done_ie,
    input  logic             ovr_ie,
    input  logic             rxff_ie,
    input  logic             txff_ie,
    input  logic             done_clr,
    input  logic             ovr_clr,
    input  logic             rxff_clr,
    input  logic             txff_clr,
    output logic             irq_rx,
    output logic             irq_tx,
    output logic             done_flag,
    output logic             ovr_flag,
    output logic             rxff_flag,
    output logic             txff_flag
);
    irq_mode_e mode;
    irq_src_t  src;
    irq_en_t   en;
    logic      ovr_req;

    assign mode = irq_mode_e'(fifo_mode);

    spi_irq_xfer_flags u_xfer (
        .clk       (clk),
        .rst       (rst),
        .xfer_done (xfer_done),
        .rxbuf_rd  (rxbuf_rd),
        .done_clr  (done_clr),
        .ovr_clr   (ovr_clr),
        .ovr_ie    (ovr_ie),
        .done_flag (done_flag),
        .ovr_flag  (ovr_flag),
        .ovr_req   (ovr_req)
    );

    spi_irq_fifo_flag #(.CNT_W(CNT_W), .IS_TX(1'b0)) u_rxff (
        .clk    (clk),
        .rst    (rst),
        .active (fifo_mode),
        .count  (rx_count),
        .level  (rx_level),
        .clr    (rxff_clr),
        .flag   (rxff_flag)
    );

    spi_irq_fifo_flag #(.CNT_W(CNT_W), .IS_TX(1'b1)) u_txff (
        .clk    (clk),
        .rst    (rst),
        .active (fifo_mode),
        .count  (tx_count),
        .level  (tx_level),
        .clr    (txff_clr),
        .flag   (txff_flag)
    );

    assign src = '{done: done_flag, ovr_req: ovr_req, rxff: rxff_flag, txff: txff_flag};
    assign en  = '{done: done_ie, ovr: ovr_ie, rxff: rxff_ie, txff: txff_ie};

    spi_irq_out u_out (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .src    (src),
        .en     (en),
        .irq_rx (irq_rx),
        .irq_tx (irq_tx)
    );

endmodule

// File: tb/test_spi_irq_gen.sv
module test_spi_irq_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fifo_mode = 0, xfer_done = 0, rxbuf_rd = 0;
    logic [CNT_W-1:0] rx_count = '0, tx_count = '0, rx_level = '0, tx_level = '0;
    logic done_ie = 0, ovr_ie = 0, rxff_ie = 0, txff_ie = 0;
    logic done_clr = 0, ovr_clr = 0, rxff_clr = 0, txff_clr = 0;
    logic irq_rx, irq_tx, done_flag, ovr_flag, rxff_flag, txff_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_gen #(.CNT_W(CNT_W)) i_spi_irq_gen (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .xfer_done(xfer_done),
        .rxbuf_rd(rxbuf_rd), .rx_count(rx_count), .tx_count(tx_count),
        .rx_level(rx_level), .tx_level(tx_level), .done_ie(done_ie),
        .ovr_ie(ovr_ie), .rxff_ie(rxff_ie), .txff_ie(txff_ie),
        .done_clr(done_clr), .ovr_clr(ovr_clr), .rxff_clr(rxff_clr),
        .txff_clr(txff_clr), .irq_rx(irq_rx), .irq_tx(irq_tx),
        .done_flag(done_flag), .ovr_flag(ovr_flag), .rxff_flag(rxff_flag),
        .txff_flag(txff_flag)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        {fifo_mode, xfer_done, rxbuf_rd, done_ie, ovr_ie, rxff_ie, txff_ie} = '0;
        {done_clr, ovr_clr, rxff_clr, txff_clr} = '0;
        rx_count = '0; tx_count = '0; rx_level = '0; tx_level = '0;
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "irq_rx", irq_rx, 1'b0);
        chk("R1", "irq_tx", irq_tx, 1'b0);
        chk("R1", "flags", |{done_flag, ovr_flag, rxff_flag, txff_flag}, 1'b0);
    endtask

    task automatic t_done();
        do_reset();
        done_ie = 1;
        xfer_done = 1; tick(); xfer_done = 0;
        chk("R2", "done_flag set", done_flag, 1'b1);
        chk("R12", "irq_rx not yet", irq_rx, 1'b0);
        tick();
        chk("R3", "irq_rx from done", irq_rx, 1'b1);
        rxbuf_rd = 1; tick(); rxbuf_rd = 0;
        chk("R2", "done_flag cleared by read", done_flag, 1'b0);
        tick();
        chk("R3", "irq_rx drops", irq_rx, 1'b0);
        xfer_done = 1; done_clr = 1; tick(); xfer_done = 0; done_clr = 0;
        chk("R2", "set wins over clear", done_flag, 1'b1);
        done_clr = 1; tick(); done_clr = 0;
        chk("R2", "done_clr clears", done_flag, 1'b0);
    endtask

    task automatic t_overrun();
        do_reset();
        ovr_ie = 1;
        xfer_done = 1; tick(2); xfer_done = 0;
        chk("R4", "ovr_flag set", ovr_flag, 1'b1);
        tick();
        chk("R5", "irq_rx from overrun", irq_rx, 1'b1);
        rxbuf_rd = 1; tick(); rxbuf_rd = 0;
        chk("R4", "read keeps ovr_flag", ovr_flag, 1'b1);
        ovr_clr = 1; tick(); ovr_clr = 0;
        chk("R4", "ovr_clr clears", ovr_flag, 1'b0);
        tick();
        chk("R5", "irq_rx drops after clear", irq_rx, 1'b0);
    endtask

    task automatic t_no_retrigger();
        do_reset();
        xfer_done = 1; tick(2); xfer_done = 0;
        chk("R6", "ovr_flag set while disabled", ovr_flag, 1'b1);
        ovr_ie = 1; tick(2);
        chk("R6", "enable later no irq", irq_rx, 1'b0);
        xfer_done = 1; tick(); xfer_done = 0; tick(2);
        chk("R6", "repeat overrun no irq", irq_rx, 1'b0);
        ovr_clr = 1; tick(); ovr_clr = 0;
        xfer_done = 1; tick(); xfer_done = 0;
        chk("R5", "fresh overrun flag", ovr_flag, 1'b1);
        tick();
        chk("R5", "fresh overrun irq", irq_rx, 1'b1);
    endtask

    task automatic t_rx_fifo();
        do_reset();
        fifo_mode = 1; rx_level = 8; rx_count = 7; rx_count = 7; tx_count = 16; tx_level = 0;
        tick(2);
        chk("R7", "below level", rxff_flag, 1'b0);
        rx_count = 8; tick();
        chk("R7", "equal sets", rxff_flag, 1'b1);
        rx_count = 0; tick();
        chk("R7", "sticky", rxff_flag, 1'b1);
        rxff_ie = 1; tick();
        chk("R12", "irq_rx one clock after enable", irq_rx, 1'b1);
        rxff_clr = 1; tick(); rxff_clr = 0;
        chk("R9", "clear", rxff_flag, 1'b0);
        tick();
        chk("R10", "irq_rx drops", irq_rx, 1'b0);
        rx_count = 16; rx_level = 16; tick();
        chk("R7", "full equal", rxff_flag, 1'b1);
        rxff_clr = 1; tick(); rxff_clr = 0;
        chk("R9", "clear while holding", rxff_flag, 1'b0);
        tick();
        chk("R9", "re-sets", rxff_flag, 1'b1);
    endtask

    task automatic t_tx_fifo();
        do_reset();
        fifo_mode = 1; tx_level = 4; tx_count = 5; rx_level = 16;
        tick(2);
        chk("R8", "above level", txff_flag, 1'b0);
        tx_count = 4; tick();
        chk("R8", "equal sets", txff_flag, 1'b1);
        txff_ie = 1; tick();
        chk("R11", "irq_tx in FIFO mode", irq_tx, 1'b1);
        fifo_mode = 0; tick();
        chk("R11", "irq_tx low in single mode", irq_tx, 1'b0);
        txff_clr = 1; tick(); txff_clr = 0;
        chk("R9", "tx clear", txff_flag, 1'b0);
        tick();
        chk("R8", "no set in single mode", txff_flag, 1'b0);
    endtask

    task automatic t_fifo_masks_single();
        do_reset();
        fifo_mode = 1; rx_level = 16; rx_count = 0; tx_count = 16; tx_level = 0; done_ie = 1;
        xfer_done = 1; tick(); xfer_done = 0; tick(2);
        chk("R10", "done_flag set", done_flag, 1'b1);
        chk("R10", "done hidden in FIFO mode", irq_rx, 1'b0);
        fifo_mode = 0; tick(2);
        chk("R3", "done shown in single mode", irq_rx, 1'b1);
    endtask

    initial begin
        t_reset();
        t_done();
        t_overrun();
        t_no_retrigger();
        t_rx_fifo();
        t_tx_fifo();
        t_fifo_masks_single();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule